// File: doc/BRIEF.md
# SPI Master with Mode-Fault Fallback

This block is a byte-wide serial master for the four-wire SPI bus. A write on its register-style port loads one byte into the shifter and starts the serial clock at once. Eight bits go out on MOSI, most significant bit first, and eight bits are taken in from MISO. The received byte is copied into a receive buffer that the reader sees on `rd_data`. An interrupt flag is raised when the byte is complete. The clock runs in mode 0: SCK idles low, MOSI moves while SCK is low, and MISO is taken on the rising edge. SCK is the system clock divided by 4.

The block does not select slaves. User logic drives the select lines of the slaves through general outputs and decides where a transfer ends. The `ss_in` pin watches the bus for another master. While the block is master, `ss_in` must stay high. If it is seen low, the block gives up the bus. It drops to slave mode, releases its SCK and MOSI drivers, abandons any byte in flight and raises the flag. A `go_master` pulse returns the block to master mode, and only while `ss_in` is high.

The sequencer has four states:
- `ST_IDLE`: master, no byte in flight.
- `ST_LOW`: SCK low half of a bit.
- `ST_HIGH`: SCK high half of a bit.
- `ST_SLAVE`: fallen back after a mode fault.

The transitions are:
- *start*: IDLE→LOW, on a write.
- *rise*: LOW→HIGH, at the end of a half period, when MISO is sampled.
- *fall*: HIGH→LOW, at the end of a half period with bits left, when MOSI shifts.
- *finish*: HIGH→IDLE, after the eighth high half.
- *fault*: IDLE, LOW or HIGH→SLAVE, when `ss_in` is low.
- *resume*: SLAVE→IDLE, on `go_master` with `ss_in` high.

Top module: `spi_host_fallback`

## Requirements
- R1: After reset the block is in master mode and idle. `sck_o`=0, `busy`=0, `irq_flag`=0, `rd_data`=0, and `sck_oe`=`mosi_oe`=1.
- R2: A `wr_en` in master idle with `ss_in` high raises `busy` at the next edge. `busy` then stays high for exactly 32 clock cycles. Within that time SCK makes 8 pulses, each 2 cycles low then 2 cycles high, and SCK is low whenever `busy` is low.
- R3: MOSI carries the written byte MSB first. It changes only while SCK is low and is stable while SCK is high.
- R4: MISO is sampled at each SCK rising edge, MSB first. The assembled byte appears on `rd_data` in the cycle `busy` falls. It stays unchanged until the next completed byte.
- R5: `irq_flag` rises in the cycle `busy` falls after a complete byte. An `rd_en` pulse clears it at the next edge. A set in the same cycle as `rd_en` wins.
- R6: A `wr_en` while `busy` is high is ignored. The byte in flight is shifted out unchanged.
- R7: A write in the first idle cycle after a byte starts the next byte with no gap cycles.
- R8: If `ss_in` is sampled low in master mode, then at the next edge `is_master`=0, `sck_oe`=`mosi_oe`=0, `busy`=0, `sck_o`=0 and `irq_flag`=1. `rd_data` keeps its previous byte.
- R9: In slave mode `wr_en` is ignored: `busy` and `sck_o` stay 0 and `rd_data` is unchanged.
- R10: `go_master` returns the block to master mode only when `ss_in` is high. With `ss_in` low it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe; clears the flag |
| go_master | input | 1 | Request to re-enter master mode |
| ss_in | input | 1 | Bus select input, watched for mode fault |
| miso_i | input | 1 | Serial data in |
| rd_data | output | 8 | Receive buffer |
| irq_flag | output | 1 | Byte done or mode fault |
| is_master | output | 1 | Mode bit, 1 = master |
| busy | output | 1 | Byte in flight |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | SCK driver enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | MOSI driver enable |

## Verification
A wrong sequencer state shows up within a single 4-cycle bit period. It appears as a pulse count or `busy` length other than 32 cycles, or as SCK toggling outside a byte. A wrong shifter or sampling point corrupts the MOSI bit stream captured on SCK rises, or the byte on `rd_data` when `busy` falls. Every one of the 256 transmit values is swept against a distinct reply byte. A missed fault response shows one edge after `ss_in` drops: the enables, the mode bit or the flag are wrong, both in idle and in the middle of a byte.

// File: rtl/spi_fb_pkg.sv
package spi_fb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_SLAVE = 2'd3
    } spi_fb_state_e;
endpackage

// File: rtl/spi_fb_seq.sv
module spi_fb_seq
    import spi_fb_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic go_master,
    input  logic ss_in,
    output logic load,
    output logic sample,
    output logic shift,
    output logic done,
    output logic fault,
    output logic busy,
    output logic sck,
    output logic master
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_W - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(HALF_CYC - 1);

    spi_fb_state_e state, nxt;
    logic [CW-1:0] ph_cnt;
    logic [BW-1:0] bit_cnt;
    logic          half_end, bit_last, running;

    assign half_end = (ph_cnt == HALF_LAST);
    assign bit_last = (bit_cnt == BIT_LAST);
    assign running  = (state == ST_LOW) || (state == ST_HIGH);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (fault) nxt = ST_SLAVE;
                      else if (wr_en) nxt = ST_LOW;
            ST_LOW:   if (fault) nxt = ST_SLAVE;
                      else if (half_end) nxt = ST_HIGH;
            ST_HIGH:  if (fault) nxt = ST_SLAVE;
                      else if (half_end) nxt = bit_last ? ST_IDLE : ST_LOW;
            ST_SLAVE: if (go_master && ss_in) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        master = (state != ST_SLAVE);
        fault  = master && !ss_in;
        busy   = running;
        sck    = (state == ST_HIGH);
        load   = (state == ST_IDLE) && !fault && wr_en;
        sample = (state == ST_LOW)  && !fault && half_end;
        shift  = (state == ST_HIGH) && !fault && half_end && !bit_last;
        done   = (state == ST_HIGH) && !fault && half_end && bit_last;
    end

    // half-period and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt  <= '0;
            bit_cnt <= '0;
        end else begin
            if (!running || half_end) ph_cnt <= '0;
            else                      ph_cnt <= ph_cnt + 1'b1;
            if (load)       bit_cnt <= '0;
            else if (shift) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // R2
    // load_starts_chk
    load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

    // R9
    // slave_exit_chk
    slave_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLAVE) |=> (state == ST_SLAVE || state == ST_IDLE));
endmodule

// File: rtl/spi_fb_shift.sv
module spi_fb_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sample,
    input  logic              shift,
    input  logic              done,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_buf
);
    logic [DATA_W-1:0] sh;
    logic              samp;

    assign mosi = sh[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            samp   <= 1'b0;
            rx_buf <= '0;
        end else begin
            if (load)        sh <= load_data;
            else if (shift)  sh <= {sh[DATA_W-2:0], samp};
            if (sample)      samp <= miso;
            if (done)        rx_buf <= {sh[DATA_W-2:0], samp};
        end
    end
endmodule

// File: rtl/spi_host_fallback.sv
module spi_host_fallback #(
    parameter int DATA_W   = 8,
    parameter int HALF_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              go_master,
    input  logic              ss_in,
    input  logic              miso_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_flag,
    output logic              is_master,
    output logic              busy,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              mosi_o,
    output logic              mosi_oe
);
    logic load, sample, shift, done, fault;

    spi_fb_seq #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .go_master(go_master),
        .ss_in(ss_in), .load(load), .sample(sample), .shift(shift),
        .done(done), .fault(fault), .busy(busy), .sck(sck_o),
        .master(is_master)
    );

    spi_fb_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(wr_data),
        .sample(sample), .shift(shift), .done(done), .miso(miso_i),
        .mosi(mosi_o), .rx_buf(rd_data)
    );

    assign sck_oe  = is_master;
    assign mosi_oe = is_master;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             irq_flag <= 1'b0;
        else if (done || fault) irq_flag <= 1'b1;
        else if (rd_en)         irq_flag <= 1'b0;
    end

    // R5
    // flag_source_chk
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ($fell(busy) || $fell(is_master)));

    // R8
    // fault_release_chk
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !ss_in) |=> (!is_master && irq_flag && !sck_oe && !mosi_oe && !busy));

    // R3
    // mosi_hold_chk
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    // R4
    // rx_update_chk
    rx_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> ($fell(busy) && is_master));
endmodule

// File: tb/spi_host_fallback_test.sv
module spi_host_fallback_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       go_master = 1'b0;
    logic       ss_in = 1'b1;
    logic       miso_i = 1'b0;
    logic [7:0] rd_data;
    logic       irq_flag, is_master, busy, sck_o, sck_oe, mosi_o, mosi_oe;

    int total = 0;
    int bad = 0;
    logic [7:0] last_rx = '0;

    always #10 clk = ~clk;

    spi_host_fallback uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .go_master(go_master), .ss_in(ss_in), .miso_i(miso_i),
        .rd_data(rd_data), .irq_flag(irq_flag), .is_master(is_master),
        .busy(busy), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o),
        .mosi_oe(mosi_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one byte; poke = write during busy, rd_last = read in the done cycle
    task automatic xfer(input logic [7:0] tx, input logic [7:0] slv,
                        input bit poke, input bit rd_last, input bit clr_after);
        logic [7:0] got = '0;
        int n = 0;
        int hi = 0;
        miso_i  = slv[7];
        wr_data = tx;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(busy == 1'b1, "R7 busy after write", busy, 1);
        fork
            begin
                for (int b = 0; b < 8; b++) begin
                    wait (sck_o == 1'b1);
                    #1 got[7-b] = mosi_o;
                    wait (sck_o == 1'b0);
                    #1 if (b < 7) miso_i = slv[6-b];
                end
            end
            begin
                while (busy) begin
                    n++;
                    if (sck_o) hi++;
                    if (poke && n == 10) begin
                        wr_en = 1'b1; wr_data = ~tx;
                    end else wr_en = 1'b0;
                    rd_en = (rd_last && n == 32);
                    @(negedge clk);
                end
                wr_en = 1'b0;
                rd_en = 1'b0;
            end
        join
        chk(n == 32, "R2 busy length", n, 32);
        chk(hi == 16, "R2 sck high cycles", hi, 16);
        chk(sck_o == 1'b0, "R2 sck idle low", sck_o, 0);
        chk(got == tx, poke ? "R6 mosi ignores busy write" : "R3 mosi stream", got, tx);
        chk(rd_data == slv, "R4 receive byte", rd_data, slv);
        chk(irq_flag == 1'b1, rd_last ? "R5 set wins over read" : "R5 flag at done", irq_flag, 1);
        last_rx = slv;
        if (clr_after) begin
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            chk(irq_flag == 1'b0, "R5 read clears flag", irq_flag, 0);
        end
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(is_master == 1'b1, "R1 master after reset", is_master, 1);
        chk(busy == 1'b0 && sck_o == 1'b0, "R1 idle after reset", {busy, sck_o}, 0);
        chk(irq_flag == 1'b0, "R1 flag clear", irq_flag, 0);
        chk(rd_data == 8'h00, "R1 rx buffer zero", rd_data, 0);
        chk(sck_oe && mosi_oe, "R1 drivers enabled", {sck_oe, mosi_oe}, 3);

        // full sweep of transmit bytes, back-to-back on even bytes (R7)
        for (int i = 0; i < 256; i++)
            xfer(8'(i), 8'(i) ^ 8'hA5 ^ 8'(i << 3), 1'b0, 1'b0, i[0]);

        // R6 write during busy, R5 set vs read
        xfer(8'h3C, 8'h81, 1'b1, 1'b0, 1'b1);
        xfer(8'hC3, 8'h7E, 1'b0, 1'b1, 1'b1);

        // R8 fault while idle
        ss_in = 1'b0;
        @(negedge clk);
        chk(is_master == 1'b0, "R8 mode bit drops", is_master, 0);
        chk(!sck_oe && !mosi_oe, "R8 drivers released", {sck_oe, mosi_oe}, 0);
        chk(irq_flag == 1'b1, "R8 flag on fault", irq_flag, 1);

        // R9 write ignored in slave mode
        wr_data = 8'hFF; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        for (int k = 0; k < 6; k++) begin
            chk(busy == 1'b0 && sck_o == 1'b0, "R9 no transfer in slave", {busy, sck_o}, 0);
            @(negedge clk);
        end
        chk(rd_data == last_rx, "R9 rx kept", rd_data, last_rx);

        // R10 resume blocked while select low
        go_master = 1'b1;
        @(negedge clk);
        go_master = 1'b0;
        chk(is_master == 1'b0, "R10 resume ignored with ss low", is_master, 0);
        ss_in = 1'b1;
        @(negedge clk);
        chk(is_master == 1'b0, "R10 no resume without request", is_master, 0);
        go_master = 1'b1;
        @(negedge clk);
        go_master = 1'b0;
        chk(is_master && sck_oe && mosi_oe, "R10 resume to master", {is_master, sck_oe, mosi_oe}, 7);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(irq_flag == 1'b0, "R5 read clears fault flag", irq_flag, 0);

        // R8 fault in the middle of a byte
        miso_i = 1'b1; wr_data = 8'h96; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (9) @(negedge clk);
        ss_in = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && sck_o == 1'b0, "R8 byte abandoned", {busy, sck_o}, 0);
        chk(!is_master && !sck_oe && !mosi_oe, "R8 released mid byte", {is_master, sck_oe, mosi_oe}, 0);
        chk(irq_flag == 1'b1, "R8 flag mid byte", irq_flag, 1);
        chk(rd_data == last_rx, "R8 rx kept", rd_data, last_rx);
        ss_in = 1'b1; go_master = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        go_master = 1'b0; rd_en = 1'b0;

        // normal operation after recovery
        xfer(8'h5A, 8'hC6, 1'b0, 1'b0, 1'b1);
        finish_run();
    end
endmodule